// File: doc/BRIEF.md
# Subtractive Index Address Unit

This unit forms effective addresses by taking the selected index register away from the address field of a decoded instruction, modulo 2^15, rather than adding it. It also runs a small family of loop-control transfers. Each transfer lowers an index register by a count carried in the instruction and tests it against a fixed limit of zero, or raises it and always transfers. Because the index is subtracted, a positive index that shrinks on every pass moves the effective address upward. Loading the distance to the end of a vector and basing the address field on that end therefore walks the vector forward.

Each instruction is presented with a one-cycle start strobe. All results are registered and appear one clock later: the effective address, a transfer-taken flag with its target, and a description of any index register write. The index registers live inside the unit. A write lands on the same edge that presents the results, so a back-to-back instruction reads the new value. Selector value 0 names no register and reads as zero.

Top module: `idx_unit`

## Requirements
- R1: One clock after a start strobe, done_o is 1 and ea_o equals addr_i minus the selected index register, modulo 2^15, using the register value from before that instruction.
- R2: With xsel_i = 0, the index value is taken as zero, so ea_o = addr_i, and xr_we_o stays 0 whatever the opcode.
- R3: Opcode 1 (load) with xsel_i != 0 writes addr_i into the selected register, reports xr_we_o = 1 with xr_wdata_o = addr_i, and does not transfer.
- R4: Opcode 2 (count-down transfer): if index > decr_i (unsigned), the register becomes index minus decr_i, it is reported as written, and br_taken_o = 1 with br_target_o = addr_i. Otherwise there is no write and no transfer.
- R5: Opcode 3 (transfer on exhausted count): if index > decr_i, the register becomes index minus decr_i and there is no transfer. Otherwise br_taken_o = 1 with br_target_o = addr_i and there is no write.
- R6: Opcode 4 (increment and transfer): the register becomes index plus decr_i modulo 2^15, and br_taken_o = 1 with br_target_o = addr_i always.
- R7: Opcode 0 (address only) and the unused codes 5, 6 and 7 neither write nor transfer.
- R8: A register write takes effect on the edge that presents it, so an instruction started on the next cycle sees the new value.
- R9: After reset, done_o, br_taken_o, xr_we_o, ea_o, br_target_o, xr_sel_o and xr_wdata_o are 0, and all index registers hold 0.
- R10: In a cycle after one with start_i low, done_o, br_taken_o and xr_we_o are 0, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Opcode class |
| addr_i | input | 15 | Address field, also the transfer target |
| decr_i | input | 15 | Decrement / increment field |
| xsel_i | input | 2 | Index register selector, 0 = none |
| done_o | output | 1 | Results valid |
| ea_o | output | 15 | Effective address |
| br_taken_o | output | 1 | Transfer taken |
| br_target_o | output | 15 | Transfer target |
| xr_we_o | output | 1 | An index register was written |
| xr_sel_o | output | 2 | Register written |
| xr_wdata_o | output | 15 | Value written |

## Verification
Two functions meet in one cycle. A loop-control instruction forms its effective address from the old register value while it writes the new one, and the next strobe, arriving straight away, has to read that new value. The bench provokes this by driving start high on consecutive cycles. It runs a forward vector walk and a long random stream of mixed opcodes on a few registers, with decrement fields kept small so that both outcomes of the zero test occur often. Each result is judged against a bench model that applies the pre-update value for the address and then commits the write before it predicts the following instruction.

// File: rtl/idx_pkg.sv
// Package: shared opcode encoding for the subtractive index unit.
// Assumes a 3-bit opcode class; codes 5..7 are unused and treated as no-ops.
package idx_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADDR  = 3'd0,   // effective address only
        OP_LOAD  = 3'd1,   // index := address field
        OP_TDEC  = 3'd2,   // count down, transfer while count remains
        OP_TEXH  = 3'd3,   // count down, transfer when count is exhausted
        OP_TINC  = 3'd4    // count up, always transfer
    } idx_op_e;
endpackage

// File: rtl/idx_sub.sv
// Module: idx_sub
// Computes a - b modulo 2^W as an adder fed with the one's complement of b
// plus a carry-in of one. Purely combinational.
module idx_sub #(
    parameter int W = 15
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] d_o
);
    localparam logic [W-1:0] ONE = W'(1);

    // Complement-and-add subtraction; the carry out is dropped (wraps).
    always_comb d_o = a_i + ~b_i + ONE;
endmodule

// File: rtl/idx_regfile.sv
// Module: idx_regfile
// Holds NXR index registers addressed 1..NXR. Selector 0 reads as zero and
// cannot be written. One read port, one write port; write at the clock edge.
module idx_regfile #(
    parameter int AW  = 15,
    parameter int NXR = 3,
    localparam int SW = $clog2(NXR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_sel_i,
    output logic [AW-1:0] rd_data_o,
    input  logic          we_i,
    input  logic [SW-1:0] wr_sel_i,
    input  logic [AW-1:0] wr_data_i
);
    logic [AW-1:0] regs [NXR+1];

    // Entry 0 is a constant zero standing for "no index".
    assign regs[0] = '0;

    for (genvar g = 1; g <= NXR; g++) begin : g_xr
        // Storage for one index register with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we_i && (wr_sel_i == SW'(g)))
                regs[g] <= wr_data_i;
        end
    end

    // Read mux; out-of-range selectors read as zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i <= NXR; i++)
            if (rd_sel_i == SW'(i)) rd_data_o = regs[i];
    end
endmodule

// File: rtl/idx_loop_ctrl.sv
// Module: idx_loop_ctrl
// Decides transfer and register update for one instruction from the current
// index value. Assumes the index value is zero when no register is selected.
module idx_loop_ctrl
    import idx_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic [OP_W-1:0] op_i,
    input  logic            sel_nz_i,
    input  logic [AW-1:0]   xval_i,
    input  logic [AW-1:0]   decr_i,
    input  logic [AW-1:0]   addr_i,
    output logic            take_o,
    output logic            wr_o,
    output logic [AW-1:0]   wr_val_o
);
    logic [AW-1:0] down_val;
    logic [AW-1:0] up_val;
    logic          remains;

    idx_sub #(.W(AW)) u_down (.a_i(xval_i), .b_i(decr_i), .d_o(down_val));

    // Count remains while index is strictly above the step; limit is zero.
    always_comb remains = xval_i > decr_i;
    // Upward step for the increment-and-transfer form.
    always_comb up_val = xval_i + decr_i;

    // Per-opcode outcome.
    always_comb begin
        take_o   = 1'b0;
        wr_o     = 1'b0;
        wr_val_o = down_val;
        case (idx_op_e'(op_i))
            OP_LOAD: begin
                wr_o     = sel_nz_i;
                wr_val_o = addr_i;
            end
            OP_TDEC: begin
                take_o = remains;
                wr_o   = remains && sel_nz_i;
            end
            OP_TEXH: begin
                take_o = !remains;
                wr_o   = remains && sel_nz_i;
            end
            OP_TINC: begin
                take_o   = 1'b1;
                wr_o     = sel_nz_i;
                wr_val_o = up_val;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idx_unit.sv
// Module: idx_unit (top)
// Subtractive index address unit: registered effective address, loop-control
// transfer decision and index register update, one clock after start_i.
// Assumes the instruction fields are stable in the cycle start_i is high.
module idx_unit
    import idx_pkg::*;
#(
    parameter int AW  = 15,
    parameter int NXR = 3,
    localparam int SW = $clog2(NXR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [AW-1:0]   decr_i,
    input  logic [SW-1:0]   xsel_i,
    output logic            done_o,
    output logic [AW-1:0]   ea_o,
    output logic            br_taken_o,
    output logic [AW-1:0]   br_target_o,
    output logic            xr_we_o,
    output logic [SW-1:0]   xr_sel_o,
    output logic [AW-1:0]   xr_wdata_o
);
    logic [AW-1:0] xval;
    logic [AW-1:0] ea_next;
    logic          take;
    logic          wr;
    logic [AW-1:0] wr_val;
    logic          sel_nz;
    logic          wr_go;

    always_comb sel_nz = xsel_i != '0;
    always_comb wr_go  = start_i && wr;

    idx_regfile #(.AW(AW), .NXR(NXR)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_sel_i(xsel_i), .rd_data_o(xval),
        .we_i(wr_go), .wr_sel_i(xsel_i), .wr_data_i(wr_val)
    );

    idx_sub #(.W(AW)) u_ea (.a_i(addr_i), .b_i(xval), .d_o(ea_next));

    idx_loop_ctrl #(.AW(AW)) u_ctl (
        .op_i(op_i), .sel_nz_i(sel_nz), .xval_i(xval), .decr_i(decr_i),
        .addr_i(addr_i), .take_o(take), .wr_o(wr), .wr_val_o(wr_val)
    );

    // Result registers: strobes follow start, data fields load on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            br_taken_o  <= 1'b0;
            xr_we_o     <= 1'b0;
            ea_o        <= '0;
            br_target_o <= '0;
            xr_sel_o    <= '0;
            xr_wdata_o  <= '0;
        end else begin
            done_o     <= start_i;
            br_taken_o <= start_i && take;
            xr_we_o    <= wr_go;
            if (start_i) begin
                ea_o        <= ea_next;
                br_target_o <= addr_i;
                xr_sel_o    <= xsel_i;
                xr_wdata_o  <= wr_val;
            end
        end
    end
endmodule

// File: rtl/idx_unit_chk.sv
// Module: idx_unit_chk
// Protocol checker for idx_unit, observing its ports only. Bound below.
module idx_unit_chk
    import idx_pkg::*;
#(
    parameter int AW  = 15,
    parameter int NXR = 3,
    localparam int SW = $clog2(NXR + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [OP_W-1:0] op_i,
    input logic [AW-1:0]   addr_i,
    input logic [AW-1:0]   decr_i,
    input logic [SW-1:0]   xsel_i,
    input logic            done_o,
    input logic [AW-1:0]   ea_o,
    input logic            br_taken_o,
    input logic [AW-1:0]   br_target_o,
    input logic            xr_we_o,
    input logic [SW-1:0]   xr_sel_o,
    input logic [AW-1:0]   xr_wdata_o
);
    a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && !br_taken_o && !xr_we_o));

    a_r2_raw_address: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && xsel_i == '0) |=> (ea_o == $past(addr_i) && !xr_we_o));

    a_r3_load_writes_field: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_LOAD && xsel_i != '0)
        |=> (xr_we_o && xr_wdata_o == $past(addr_i) && !br_taken_o));

    a_r4_taken_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_TDEC && xsel_i != '0) |=> (br_taken_o == xr_we_o));

    a_r5_taken_xor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_TEXH && xsel_i != '0) |=> (br_taken_o != xr_we_o));

    a_r6_always_transfers: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_TINC) |=> (br_taken_o && br_target_o == $past(addr_i)));

    a_r7_address_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == OP_ADDR || op_i > OP_TINC)) |=> (!br_taken_o && !xr_we_o));

    a_r2_write_names_register: assert property (@(posedge clk) disable iff (!rst_n)
        xr_we_o |-> (xr_sel_o != '0));
endmodule

bind idx_unit idx_unit_chk #(.AW(AW), .NXR(NXR)) u_chk (.*);

// File: tb/idx_unit_tb.sv
module idx_unit_tb;
    localparam int AW = 15;
    localparam int SW = 2;
    localparam logic [AW-1:0] M = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] decr_i = '0;
    logic [SW-1:0] xsel_i = '0;
    logic          done_o, br_taken_o, xr_we_o;
    logic [AW-1:0] ea_o, br_target_o, xr_wdata_o;
    logic [SW-1:0] xr_sel_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [AW-1:0] mx [4];

    always #2 clk = ~clk;

    idx_unit u_dut (.*);

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            report();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Issue one instruction at a falling edge, sample at the next falling edge.
    task automatic issue(logic [2:0] op, logic [SW-1:0] sel,
                         logic [AW-1:0] a, logic [AW-1:0] d);
        logic [AW-1:0] x, e_ea, e_wv;
        logic e_br, e_we, rem;
        x    = mx[sel];
        e_ea = (a - x) & M;
        rem  = x > d;
        e_br = 1'b0; e_we = 1'b0; e_wv = '0;
        case (op)
            3'd1: begin e_we = 1'b1; e_wv = a; end                    // R3
            3'd2: begin e_br = rem;  e_we = rem; e_wv = x - d; end    // R4
            3'd3: begin e_br = !rem; e_we = rem; e_wv = x - d; end    // R5
            3'd4: begin e_br = 1'b1; e_we = 1'b1; e_wv = (x + d) & M; end // R6
            default: ;                                                // R7
        endcase
        if (sel == 0) e_we = 1'b0;                                    // R2
        start_i = 1'b1; op_i = op; xsel_i = sel; addr_i = a; decr_i = d;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 done", done_o, 1);
        chk(sel == 0 ? "R2 raw ea" : "R1 ea", ea_o, e_ea);
        chk(op == 3'd2 ? "R4 taken" : op == 3'd3 ? "R5 taken" :
            op == 3'd4 ? "R6 taken" : "R7 taken", br_taken_o, e_br);
        if (e_br) chk("R6 target", br_target_o, a);
        chk(op == 3'd1 ? "R3 write" : op == 3'd2 ? "R4 write" :
            op == 3'd3 ? "R5 write" : "R7 write", xr_we_o, e_we);
        if (e_we) begin
            chk("R8 wsel", xr_sel_o, sel);
            chk("R8 wdata", xr_wdata_o, e_wv);
            mx[sel] = e_wv;
        end
    endtask

    task automatic idle();
        start_i = 1'b0;
        op_i = 3'd1; xsel_i = 2'd1; addr_i = 15'h1234;   // would write if started
        @(negedge clk);
        chk("R10 done", done_o, 0);
        chk("R10 taken", br_taken_o, 0);
        chk("R10 we", xr_we_o, 0);
    endtask

    initial begin
        logic [AW-1:0] ea_prev;
        void'($urandom(32'd20191208));
        for (int i = 0; i < 4; i++) mx[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 done", done_o, 0);
        chk("R9 ea", ea_o, 0);
        chk("R9 taken", br_taken_o, 0);
        chk("R9 target", br_target_o, 0);
        chk("R9 we", xr_we_o, 0);
        chk("R9 wdata", {xr_sel_o, xr_wdata_o}, 0);
        for (int s = 1; s < 4; s++) issue(3'd0, SW'(s), 15'd500, 15'd0); // R9 regs zero

        // Forward walk: base 100, index 4, step 1; R8 back-to-back.
        issue(3'd1, 2'd1, 15'd4, 15'd0);
        ea_prev = '0;
        for (int k = 0; k < 4; k++) begin
            issue(3'd0, 2'd1, 15'd100, 15'd0);
            if (k > 0) chk("R8 forward step", ea_o, ea_prev + 1);
            ea_prev = ea_o;
            issue(3'd2, 2'd1, 15'd40, 15'd1);
        end
        // Wrap: 0 - 1
        issue(3'd1, 2'd2, 15'd1, 15'd0);
        issue(3'd0, 2'd2, 15'd0, 15'd0);
        chk("R1 wrap", ea_o, 15'h7FFF);
        // Equality: index == decr -> exhausted
        issue(3'd1, 2'd3, 15'd7, 15'd0);
        issue(3'd2, 2'd3, 15'd9, 15'd7);
        issue(3'd3, 2'd3, 15'd9, 15'd7);
        issue(3'd3, 2'd3, 15'd9, 15'd6);
        // Increment wrap
        issue(3'd1, 2'd2, 15'h7FFF, 15'd0);
        issue(3'd4, 2'd2, 15'd3, 15'd1);
        issue(3'd4, 2'd0, 15'd3, 15'd1);
        idle();
        issue(3'd0, 2'd1, 15'd0, 15'd0);   // R10: register unchanged by idle

        // Random mix, mostly back-to-back.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            logic [AW-1:0] a, d;
            op = 3'($urandom_range(0, 7));
            a  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 60));
            d  = ($urandom_range(0, 7) == 0) ? AW'($urandom) : AW'($urandom_range(0, 12));
            issue(op, SW'($urandom_range(0, 3)), a, d);
            if ($urandom_range(0, 15) == 0) idle();
        end
        report();
    end
endmodule